// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a clocked host to an external asynchronous static RAM holding 65,536 words of 16 bits. The host presents one access at a time on a valid/ready handshake: a 16-bit word address, 16-bit write data, a direction bit and a two-bit byte mask with one bit per byte lane. The controller turns each access into a timed sequence of active-low memory strobes. The strobe widths are counted in clock cycles, and those counts are parameters derived from the memory speed grade and the clock period.

Reads hold chip enable and output enable low for a programmed number of cycles. The data bus is sampled at the end of that window, and the word is returned with a one-cycle valid pulse. Writes hold write enable low with the controller's drivers on, then raise write enable for one more cycle while address and data stay put. The memory latches data on that rising edge.

Byte lanes are enabled individually. The controller never drives the shared bus while the memory's outputs may be on. Between accesses everything returns to standby.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and in every cycle with no access in progress, the controller is in standby. Chip enable, write enable and output enable are high, both byte enables are high, the data drivers are off, and `ready` is high.
- R2: A request is taken on a rising clock edge where `req_valid` and `ready` are both high. `ready` is low from the next cycle for RD_CYC+1 cycles (read) or WR_CYC+1 cycles (write). A request presented while `ready` is low is ignored and causes no memory access.
- R3: For the RD_CYC cycles after a read is taken, chip enable and output enable are low and write enable is high. `mem_addr` holds the request address, and `mem_be_n[i]` is the inverse of mask bit i.
- R4: Read data is sampled at the end of the last read strobe cycle. In the following cycle `rd_valid` is high for exactly one cycle with the word on `rd_data`. A lane whose mask bit is 0 reads as zero.
- R5: The cycle after a read strobe is a turnaround cycle. Output enable and chip enable are high, the data drivers stay off, and the byte enables are high.
- R6: For the WR_CYC cycles after a write is taken, chip enable and write enable are low and output enable is high. The data drivers are on with `mem_dq_o` equal to the write data, and `mem_be_n` is the inverse of the mask.
- R7: A write strobe is followed by one hold cycle. Write enable returns high while chip enable stays low and the drivers stay on. Address, data and byte enables are unchanged from the strobe, so the rising edge of write enable commits them.
- R8: Mask bit 0 controls lane bits 7..0 (`mem_be_n[0]`), and mask bit 1 controls bits 15..8 (`mem_be_n[1]`). A write with one mask bit set changes only that byte of the stored word.
- R9: The data drivers are never on in a cycle where output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane mask, bit 0 = bits 7..0 |
| ready | output | 1 | Controller idle, request can be taken |
| rd_data | output | 16 | Read word, unmasked lanes zero |
| rd_valid | output | 1 | One-cycle read data strobe |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 0 = lower lane |
| mem_dq_o | output | 16 | Data to the bus |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data from the bus |

## Verification
Counting from the edge that takes a request, `ready` and the strobes change in the very next cycle. `rd_valid` arrives RD_CYC+1 cycles after that edge, and the write commit (write enable rising) arrives WR_CYC+1 cycles after it. The bench keeps a countdown per access in its model, so the expected phase is known in every cycle, and it compares every output at the falling edge, half a cycle after the registers update. The bench's own memory model commits on a sampled rising write enable and drives disabled lanes with junk. The masking checks and the byte-merge readback therefore rest on the bus itself, not on the model's shadow copy.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the asynchronous SRAM controller.
package sram_ctrl_pkg;

    // Access sequencer phases.
    typedef enum logic [2:0] {
        ST_IDLE,   // standby, ready for a request
        ST_RD,     // read strobe window
        ST_RGAP,   // bus turnaround after a read
        ST_WR,     // write strobe window
        ST_WHOLD   // write enable high, data held
    } seq_state_t;

endpackage

// File: rtl/sram_ctrl_seq.sv
// Access sequencer: steps through the strobe phases of one access and
// times the read and write windows with a down counter.
// Assumes RD_CYC >= 1 and WR_CYC >= 1; start is only raised in ST_IDLE.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_wr,
    output seq_state_t state,
    output logic       capture
);
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic [CNT_W-1:0] cnt;

    // Phase register and window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= start_wr ? ST_WR : ST_RD;
                    cnt   <= start_wr ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
                end
                ST_RD: begin
                    if (cnt == '0) state <= ST_RGAP;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_RGAP: state <= ST_IDLE;
                ST_WR: begin
                    if (cnt == '0) state <= ST_WHOLD;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_WHOLD: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Last cycle of the read window: sample the bus at its closing edge.
    assign capture = (state == ST_RD) && (cnt == '0);

endmodule

// File: rtl/sram_ctrl_lanes.sv
// Request holding registers and per-lane read capture.
// Holds address, write data and mask steady for the whole access; a lane
// whose mask bit is clear captures zero rather than the floating bus.
module sram_ctrl_lanes #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [LANES-1:0]  mask_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  mask_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANE_W = DATA_W / LANES;

    // Latch the accepted request for the duration of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (load) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
            mask_q  <= mask_in;
        end
    end

    // One-cycle valid pulse following the capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= capture;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        // Capture this lane, or zero when it was not requested.
        always_ff @(posedge clk) begin
            if (!rst_n)       lane_q <= '0;
            else if (capture) lane_q <= mask_q[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/sram_ctrl.sv
// Asynchronous SRAM controller top.
// Takes one host access at a time and produces active-low memory strobes
// decoded from the sequencer phase. Assumes the external bus is resolved
// from mem_dq_o/mem_dq_oe outside this block, and that RD_CYC and WR_CYC
// cover the memory's access and write-pulse times at the chosen clock.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int RD_CYC = 3,
    parameter int WR_CYC = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_mask,
    output logic                  ready,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [DATA_W-1:0]     mem_dq_o,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_i
);
    localparam int LANES = DATA_W / 8;

    seq_state_t        state;
    logic              capture;
    logic              accept;
    logic [LANES-1:0]  mask_q;
    logic              active;

    assign accept = req_valid && ready;

    sram_ctrl_seq #(
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_wr (req_write),
        .state    (state),
        .capture  (capture)
    );

    sram_ctrl_lanes #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .mask_in  (req_mask),
        .capture  (capture),
        .dq_i     (mem_dq_i),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_o),
        .mask_q   (mask_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Strobe decode from the sequencer phase.
    always_comb begin
        active    = (state == ST_RD) || (state == ST_WR) || (state == ST_WHOLD);
        ready     = (state == ST_IDLE);
        mem_ce_n  = !active;
        mem_oe_n  = (state != ST_RD);
        mem_we_n  = (state != ST_WR);
        mem_dq_oe = (state == ST_WR) || (state == ST_WHOLD);
        mem_be_n  = active ? ~mask_q : '1;
    end

endmodule

// File: rtl/sram_ctrl_chk.sv
// Protocol checker for sram_ctrl: standby quietness, bus contention,
// turnaround and write-hold stability. Bound to every sram_ctrl instance.
module sram_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                ready,
    input logic                rd_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                mem_ce_n,
    input logic                mem_we_n,
    input logic                mem_oe_n,
    input logic [DATA_W/8-1:0] mem_be_n,
    input logic [DATA_W-1:0]   mem_dq_o,
    input logic                mem_dq_oe
);
    a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n)));

    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);

    a_r3_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (!mem_dq_oe && mem_ce_n));

    a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_ce_n && mem_oe_n));

    a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && $stable(mem_be_n)));

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_test.sv
`timescale 1ns/1ps
module sram_ctrl_test;
    localparam int RD = 3;
    localparam int WR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        ready, rd_valid;
    logic [15:0] rd_data, mem_addr, mem_dq_o, mem_dq_i;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sram_ctrl #(.RD_CYC(RD), .WR_CYC(WR)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Device model: array contents, read drive, commit on rising write enable.
    logic [15:0] dev_mem [int];
    logic [15:0] ref_mem [int];
    logic        prev_we = 1'b1;

    function automatic logic [15:0] dev_word(input logic [15:0] a);
        return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : 16'h0000;
    endfunction
    function automatic logic [15:0] ref_word(input logic [15:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    endfunction

    always_comb begin
        logic [15:0] w;
        w = dev_word(mem_addr);
        mem_dq_i = 16'hEEEE;   // stands in for a floating lane
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_be_n[0]) mem_dq_i[7:0]  = w[7:0];
            if (!mem_be_n[1]) mem_dq_i[15:8] = w[15:8];
        end
    end

    // Reference model state: countdown of the access in progress.
    int          rem = 0;
    bit          m_wr = 0;
    logic [15:0] m_addr = '0, m_wdata = '0, m_rd = '0;
    logic [1:0]  m_mask = '0;

    always @(posedge clk) begin
        if (!rst_n) rem = 0;
        else if (rem > 0) rem = rem - 1;
        else if (req_valid) begin
            logic [15:0] w;
            m_wr = req_write; m_addr = req_addr; m_wdata = req_wdata; m_mask = req_mask;
            rem = req_write ? WR + 1 : RD + 1;
            w = ref_word(req_addr);
            if (req_write) begin
                if (req_mask[0]) w[7:0]  = req_wdata[7:0];
                if (req_mask[1]) w[15:8] = req_wdata[15:8];
                ref_mem[int'(req_addr)] = w;
            end else begin
                m_rd = {req_mask[1] ? w[15:8] : 8'h00, req_mask[0] ? w[7:0] : 8'h00};
            end
        end
    end

    // Memory commit and its check (R7), sampled half a cycle after the edge.
    always @(negedge clk) begin
        if (rst_n && prev_we == 1'b0 && mem_we_n == 1'b1 && mem_ce_n == 1'b0) begin
            logic [15:0] w;
            chk("R7 commit address", 32'(mem_addr), 32'(m_addr));
            chk("R7 commit data", 32'(mem_dq_o), 32'(m_wdata));
            w = dev_word(mem_addr);
            if (!mem_be_n[0]) w[7:0]  = mem_dq_o[7:0];
            if (!mem_be_n[1]) w[15:8] = mem_dq_o[15:8];
            dev_mem[int'(mem_addr)] = w;
        end
        prev_we = mem_we_n;
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] act;
            act = {ready, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, rd_valid};
            chk("R9 no contention", 32'(mem_dq_oe && !mem_oe_n), 32'd0);
            if (rem == 0) begin
                chk("R1 R2 standby", 32'(act), 32'({1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0}));
            end else if (!m_wr && rem > 1) begin
                chk("R2 R3 read strobe", 32'(act), 32'({1'b0, 1'b0, 1'b1, 1'b0, ~m_mask, 1'b0, 1'b0}));
                chk("R3 read address", 32'(mem_addr), 32'(m_addr));
            end else if (!m_wr) begin
                chk("R5 turnaround", 32'(act), 32'({1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1}));
                chk("R4 R8 read data", 32'(rd_data), 32'(m_rd));
            end else if (rem > 1) begin
                chk("R2 R6 write strobe", 32'(act), 32'({1'b0, 1'b0, 1'b0, 1'b1, ~m_mask, 1'b1, 1'b0}));
                chk("R6 write address", 32'(mem_addr), 32'(m_addr));
                chk("R6 write data", 32'(mem_dq_o), 32'(m_wdata));
            end else begin
                chk("R7 write hold", 32'(act), 32'({1'b0, 1'b0, 1'b1, 1'b1, ~m_mask, 1'b1, 1'b0}));
            end
        end
    end

    task automatic issue(input bit w, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
        while (!ready) @(negedge clk);
        req_write = w; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset standby", 32'({ready, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, rd_valid}),
            32'({1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0}));
        rst_n = 1'b1;
        @(negedge clk);

        issue(1, 16'h1234, 16'hBEEF, 2'b11);
        issue(0, 16'h1234, 16'h0000, 2'b11);    // R4: BEEF
        issue(1, 16'h1234, 16'h5511, 2'b01);    // R8: lower lane only
        issue(0, 16'h1234, 16'h0000, 2'b11);    // R8: BE11
        issue(1, 16'h1234, 16'hAA77, 2'b10);    // R8: upper lane only
        issue(0, 16'h1234, 16'h0000, 2'b10);    // R4: AA00, lower lane masked
        issue(0, 16'h1234, 16'h0000, 2'b01);    // R4: 0011
        issue(0, 16'hFFFF, 16'h0000, 2'b11);    // unwritten word

        // R2: a write offered while busy must not reach the memory.
        while (!ready) @(negedge clk);
        req_write = 0; req_addr = 16'h1234; req_mask = 2'b11; req_valid = 1'b1;
        @(negedge clk);
        req_write = 1; req_addr = 16'h7777; req_wdata = 16'hDEAD;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!ready) @(negedge clk);
        issue(0, 16'h7777, 16'h0000, 2'b11);    // R2: still zero
        chk("R2 ignored write left memory alone", 32'(dev_word(16'h7777)), 32'h0);

        for (int i = 0; i < 24; i++) begin
            logic [15:0] a;
            a = 16'($urandom);
            issue(1, a, 16'($urandom), 2'($urandom));
            issue(0, a, 16'h0000, 2'($urandom));
        end

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule